// File: doc/BRIEF.md
# Descriptor Queue Status Event Generator

This block lives inside a descriptor fetch engine and turns per-queue control traffic into status records for user traffic-management logic. Software activity arrives on a single control channel, one queue per cycle. A write can carry a new producer index, a new value for the queue's interrupt-arm bit, or both at once. The same channel also carries invalidation notices, which come with the number of fetch credits the engine still holds for that queue. Per-queue attributes (direction, bypass or internal mode, stream or memory-mapped mode, enable, error, port) are supplied as static vectors.

For each enabled queue the block keeps the last reported producer index and the current arm bit. From these it forms a record holding the queue id, an available count, an arm flag, an invalidate flag and the queue's attributes. An available count is the 16-bit modulo distance from the last reported index to the new one. In an invalidate record the count instead holds the credits still held for that queue. Records pass through an eight-entry FIFO to a valid/ready output. A halt-fetch output warns the fetch side once only one free slot remains. A per-queue stop vector tells the fetcher which queues have been invalidated.

Top module: `qstat_event_gen`

## Requirements
- R1: After reset, `evt_valid`, `halt_fetch` and every bit of `fetch_stop` are 0. Every queue's last reported index is 0 and its arm bit is 0.
- R2: On an enabled queue, a control write with `ev_pidx_wr`=1 produces one record. Its `evt_avail` is (`ev_pidx` − last reported index) mod 65536 and its `evt_qinv` is 0. The queue's last reported index then becomes `ev_pidx`.
- R3: On an enabled queue, a write with `ev_arm_wr`=1 and `ev_arm`=1 produces one record. Its `evt_irq_arm` is 1 only if the stored arm bit was 0. The stored bit then becomes 1. Without a producer-index write in the same cycle, `evt_avail` is 0.
- R4: A write with `ev_arm_wr`=1 and `ev_arm`=0 and no producer-index write produces no record. It clears the stored arm bit, so a later arm-set reports `evt_irq_arm`=1.
- R5: A producer-index write and an arm-set in the same control cycle produce exactly one record. That record carries both the R2 count and the R3 arm flag.
- R6: A producer-index or arm write to a queue whose `q_enable` bit is 0 produces no record. It leaves the queue's last reported index and arm bit unchanged.
- R7: A write with `ev_inv`=1 always produces a record, whatever the other write fields hold. The record has `evt_qinv`=1, `evt_irq_arm`=0 and `evt_avail`=`ev_credits`. The invalidation clears the arm bit. If the queue is enabled it sets `fetch_stop[qid]`. That bit returns to 0 in the cycle after `q_enable[qid]` is seen low.
- R8: Each record carries the attribute bits of its queue as they stood in the control cycle: `q_dir`, `q_bypass`, `q_mm`, `q_enable`, `q_error` and the `PORT_W`-bit port field at bit offset qid·`PORT_W` of `q_port`.
- R9: Records leave in the order they were formed. A record is consumed on a cycle with `evt_valid`=1 and `evt_ready`=1. While `evt_valid`=1 and `evt_ready`=0, every output field holds its value.
- R10: `halt_fetch` is 1 exactly when 7 or more of the 8 buffer entries are occupied.
- R11: A record formed while the buffer is empty appears on `evt_valid` at the clock edge that samples the control write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_vld | input | 1 | Control write present this cycle |
| ev_qid | input | 3 | Queue addressed by the control write |
| ev_inv | input | 1 | Write is an invalidation notice |
| ev_pidx_wr | input | 1 | Write carries a new producer index |
| ev_pidx | input | 16 | New producer index |
| ev_arm_wr | input | 1 | Write carries an arm-bit value |
| ev_arm | input | 1 | Arm-bit value written |
| ev_credits | input | 16 | Fetch credits held, for invalidation notices |
| q_enable | input | 8 | Per-queue enable |
| q_error | input | 8 | Per-queue error status |
| q_dir | input | 8 | Per-queue direction, 1 = card-to-host |
| q_bypass | input | 8 | Per-queue mode, 1 = bypass |
| q_mm | input | 8 | Per-queue mode, 1 = memory-mapped |
| q_port | input | 16 | Per-queue port id, 2 bits per queue |
| evt_ready | input | 1 | Consumer accepts the head record |
| evt_valid | output | 1 | Head record present |
| evt_qid | output | 3 | Record queue id |
| evt_avail | output | 16 | New descriptors, or held credits on invalidation |
| evt_irq_arm | output | 1 | Arm bit went from 0 to 1 |
| evt_qinv | output | 1 | Invalidation record |
| evt_dir | output | 1 | Queue direction |
| evt_bypass | output | 1 | Queue bypass mode |
| evt_mm | output | 1 | Queue memory-mapped mode |
| evt_enable | output | 1 | Queue enable at event time |
| evt_error | output | 1 | Queue error at event time |
| evt_port | output | 2 | Queue port id |
| halt_fetch | output | 1 | Buffer nearly full, stop making events |
| fetch_stop | output | 8 | Per-queue stop after invalidation |

## Verification
The hardest case to reach is a buffer that sits at seven entries with its head held. Here `halt_fetch` must be high, the payload frozen, and the order preserved once draining starts. The stimulus holds `evt_ready` low and keeps issuing producer-index writes while `halt_fetch` reads low. It then checks that exactly seven were accepted before draining. Index wraparound and the arm bit's 0-to-1 history are reached by directed write sequences to chosen queues. A long mixed phase follows, with random ready, enable toggling and invalidations. In every phase a behavioural model is compared with every output on every clock.

// File: rtl/qstat_pkg.sv
package qstat_pkg;

   // Static per-queue attributes carried into every record
   typedef struct packed {
      logic dir;     // 1 = card-to-host
      logic bypass;  // 1 = bypass mode
      logic mm;      // 1 = memory-mapped
      logic enable;
      logic error;
   } qattr_t;

   localparam int ATTR_W = $bits(qattr_t);

   function automatic int qid_width(input int nq);
      return (nq > 1) ? $clog2(nq) : 1;
   endfunction

endpackage

// File: rtl/qstat_fifo.sv
module qstat_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 8,
   parameter int CW    = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [W-1:0]  din,
   input  logic          pop,
   output logic [W-1:0]  dout,
   output logic          empty,
   output logic [CW-1:0] count
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic          full, do_pop, do_push;

   assign empty   = (count == '0);
   assign full    = (count == CW'(DEPTH));
   assign do_pop  = pop && !empty;
   assign do_push = push && (!full || do_pop);
   assign dout    = mem[rd_ptr];

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_wrap
         assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_nxt;
         if (do_pop)  rd_ptr <= rd_nxt;
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   // R9: head record is held while not consumed
   a_r9_hold_head: assert property (@(posedge clk) disable iff (!rst_n)
      (!empty && !pop) |=> (!empty && $stable(dout)));

   // R10: no record arrives at a full buffer without a pop
   a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      !(push && full && !pop));

   // R11: a record pushed into an empty buffer is visible next cycle
   a_r11_fill_latency: assert property (@(posedge clk) disable iff (!rst_n)
      (push && empty) |=> !empty);

endmodule

// File: rtl/qstat_queue_ctrl.sv
module qstat_queue_ctrl #(
   parameter int NUM_Q = 8,
   parameter int IDX_W = 16,
   parameter int QID_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ev_vld,
   input  logic [QID_W-1:0] ev_qid,
   input  logic             ev_inv,
   input  logic             ev_pidx_wr,
   input  logic [IDX_W-1:0] ev_pidx,
   input  logic             ev_arm_wr,
   input  logic             ev_arm,
   input  logic [IDX_W-1:0] ev_credits,
   input  logic [NUM_Q-1:0] q_enable,
   output logic             rec_push,
   output logic [IDX_W-1:0] rec_avail,
   output logic             rec_irq,
   output logic             rec_inv,
   output logic [NUM_Q-1:0] fetch_stop
);
   logic [IDX_W-1:0] last_q [NUM_Q];
   logic [NUM_Q-1:0] arm_q, stop_q;

   logic             qid_ok, sel_en, sel_arm;
   logic [IDX_W-1:0] sel_last;
   logic             inv_hit, upd_hit, arm_set;

   // Decode the addressed queue's state without out-of-range indexing
   always_comb begin
      qid_ok   = 1'b0;
      sel_en   = 1'b0;
      sel_arm  = 1'b0;
      sel_last = '0;
      for (int i = 0; i < NUM_Q; i++) begin
         if (ev_qid == QID_W'(i)) begin
            qid_ok   = 1'b1;
            sel_en   = q_enable[i];
            sel_arm  = arm_q[i];
            sel_last = last_q[i];
         end
      end
   end

   assign inv_hit  = ev_vld && qid_ok && ev_inv;
   assign upd_hit  = ev_vld && qid_ok && !ev_inv && sel_en;
   assign arm_set  = ev_arm_wr && ev_arm;

   assign rec_push  = inv_hit || (upd_hit && (ev_pidx_wr || arm_set));
   assign rec_inv   = inv_hit;
   assign rec_irq   = !inv_hit && arm_set && !sel_arm;
   assign rec_avail = inv_hit    ? ev_credits :
                      ev_pidx_wr ? (ev_pidx - sel_last) : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         arm_q  <= '0;
         stop_q <= '0;
         for (int i = 0; i < NUM_Q; i++) last_q[i] <= '0;
      end else begin
         for (int i = 0; i < NUM_Q; i++) begin
            if (ev_qid == QID_W'(i)) begin
               if (inv_hit) begin
                  arm_q[i] <= 1'b0;
               end else if (upd_hit) begin
                  if (ev_pidx_wr) last_q[i] <= ev_pidx;
                  if (ev_arm_wr)  arm_q[i]  <= ev_arm;
               end
            end
            if (!q_enable[i])
               stop_q[i] <= 1'b0;
            else if (inv_hit && ev_qid == QID_W'(i))
               stop_q[i] <= 1'b1;
         end
      end
   end

   assign fetch_stop = stop_q;

   // R2: the reported index follows the producer-index write
   a_r2_last_tracks: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_hit && ev_pidx_wr) |=> (last_q[$past(ev_qid)] == $past(ev_pidx)));

   // R3: an arm flag in a record leaves the arm bit set
   a_r3_arm_after_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (rec_push && rec_irq) |=> arm_q[$past(ev_qid)]);

   // R6: a disabled queue keeps its state across a non-invalidate write
   a_r6_disabled_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_vld && qid_ok && !ev_inv && !sel_en)
         |=> ($stable(arm_q) && last_q[$past(ev_qid)] == $past(sel_last)));

   // R7: invalidating an enabled queue raises its stop bit
   a_r7_stop_set: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_hit && sel_en) |=> fetch_stop[$past(ev_qid)]);

   // R7: an invalidate record never carries the arm flag
   a_r7_no_arm_on_inv: assert property (@(posedge clk) disable iff (!rst_n)
      rec_inv |-> !rec_irq);

endmodule

// File: rtl/qstat_event_gen.sv
module qstat_event_gen
   import qstat_pkg::*;
#(
   parameter int NUM_Q       = 8,
   parameter int IDX_W       = 16,
   parameter int PORT_W      = 2,
   parameter int FIFO_DEPTH  = 8,
   parameter int HALT_MARGIN = 1,
   parameter int QID_W       = qid_width(NUM_Q)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    ev_vld,
   input  logic [QID_W-1:0]        ev_qid,
   input  logic                    ev_inv,
   input  logic                    ev_pidx_wr,
   input  logic [IDX_W-1:0]        ev_pidx,
   input  logic                    ev_arm_wr,
   input  logic                    ev_arm,
   input  logic [IDX_W-1:0]        ev_credits,
   input  logic [NUM_Q-1:0]        q_enable,
   input  logic [NUM_Q-1:0]        q_error,
   input  logic [NUM_Q-1:0]        q_dir,
   input  logic [NUM_Q-1:0]        q_bypass,
   input  logic [NUM_Q-1:0]        q_mm,
   input  logic [NUM_Q*PORT_W-1:0] q_port,
   input  logic                    evt_ready,
   output logic                    evt_valid,
   output logic [QID_W-1:0]        evt_qid,
   output logic [IDX_W-1:0]        evt_avail,
   output logic                    evt_irq_arm,
   output logic                    evt_qinv,
   output logic                    evt_dir,
   output logic                    evt_bypass,
   output logic                    evt_mm,
   output logic                    evt_enable,
   output logic                    evt_error,
   output logic [PORT_W-1:0]       evt_port,
   output logic                    halt_fetch,
   output logic [NUM_Q-1:0]        fetch_stop
);
   localparam int REC_W    = QID_W + IDX_W + 2 + ATTR_W + PORT_W;
   localparam int CNT_W    = $clog2(FIFO_DEPTH + 1);
   localparam int HALT_LVL = FIFO_DEPTH - HALT_MARGIN;

   generate
      if (NUM_Q < 1)                 begin : g_bad_nq   $error("NUM_Q must be at least 1");                end
      if (IDX_W < 2)                 begin : g_bad_idx  $error("IDX_W must be at least 2");                end
      if (PORT_W < 1)                begin : g_bad_port $error("PORT_W must be at least 1");               end
      if (FIFO_DEPTH < 2)            begin : g_bad_dep  $error("FIFO_DEPTH must be at least 2");           end
      if (HALT_MARGIN < 1 || HALT_MARGIN >= FIFO_DEPTH)
                                     begin : g_bad_mrg  $error("HALT_MARGIN must lie in 1..FIFO_DEPTH-1"); end
   endgenerate

   logic             rec_push, rec_irq, rec_inv;
   logic [IDX_W-1:0] rec_avail;
   qattr_t           sel_attr, head_attr;
   logic [PORT_W-1:0] sel_port;
   logic [REC_W-1:0] rec_word, head_word;
   logic             fifo_empty, pop;
   logic [CNT_W-1:0] fifo_count;

   qstat_queue_ctrl #(
      .NUM_Q (NUM_Q),
      .IDX_W (IDX_W),
      .QID_W (QID_W)
   ) u_qctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .ev_vld     (ev_vld),
      .ev_qid     (ev_qid),
      .ev_inv     (ev_inv),
      .ev_pidx_wr (ev_pidx_wr),
      .ev_pidx    (ev_pidx),
      .ev_arm_wr  (ev_arm_wr),
      .ev_arm     (ev_arm),
      .ev_credits (ev_credits),
      .q_enable   (q_enable),
      .rec_push   (rec_push),
      .rec_avail  (rec_avail),
      .rec_irq    (rec_irq),
      .rec_inv    (rec_inv),
      .fetch_stop (fetch_stop)
   );

   // Attribute capture for the addressed queue
   always_comb begin
      sel_attr = '0;
      sel_port = '0;
      for (int i = 0; i < NUM_Q; i++) begin
         if (ev_qid == QID_W'(i)) begin
            sel_attr.dir    = q_dir[i];
            sel_attr.bypass = q_bypass[i];
            sel_attr.mm     = q_mm[i];
            sel_attr.enable = q_enable[i];
            sel_attr.error  = q_error[i];
            sel_port        = q_port[i*PORT_W +: PORT_W];
         end
      end
   end

   assign rec_word = {ev_qid, rec_avail, rec_irq, rec_inv, sel_attr, sel_port};

   qstat_fifo #(
      .W     (REC_W),
      .DEPTH (FIFO_DEPTH),
      .CW    (CNT_W)
   ) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (rec_push),
      .din   (rec_word),
      .pop   (pop),
      .dout  (head_word),
      .empty (fifo_empty),
      .count (fifo_count)
   );

   assign evt_valid = !fifo_empty;
   assign pop       = evt_valid && evt_ready;
   assign {evt_qid, evt_avail, evt_irq_arm, evt_qinv, head_attr, evt_port} = head_word;
   assign evt_dir    = head_attr.dir;
   assign evt_bypass = head_attr.bypass;
   assign evt_mm     = head_attr.mm;
   assign evt_enable = head_attr.enable;
   assign evt_error  = head_attr.error;

   assign halt_fetch = (fifo_count >= CNT_W'(HALT_LVL));

   // R10: the halt level is only reached through a new record
   a_r10_halt_by_push: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(halt_fetch) |-> $past(rec_push));

   // R10: halt implies records are waiting
   a_r10_halt_has_data: assert property (@(posedge clk) disable iff (!rst_n)
      halt_fetch |-> evt_valid);

   // R9: an accepted record with nothing new drains the output
   a_r9_drain_last: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && fifo_count == CNT_W'(1) && !rec_push) |=> !evt_valid);

endmodule

// File: tb/sim_qstat_event_gen.sv
module sim_qstat_event_gen;
   localparam int NQ = 8;
   localparam int IW = 16;
   localparam int PW = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;   // 125 MHz

   logic           ev_vld = 0, ev_inv = 0, ev_pidx_wr = 0, ev_arm_wr = 0, ev_arm = 0;
   logic [2:0]     ev_qid = '0;
   logic [IW-1:0]  ev_pidx = '0, ev_credits = '0;
   logic [NQ-1:0]  q_enable = 8'hF7, q_error = 8'b0100_1001, q_dir = 8'b1010_0110;
   logic [NQ-1:0]  q_bypass = 8'b0011_1100, q_mm = 8'b1100_0101;
   logic [NQ*PW-1:0] q_port = 16'b11_10_01_00_11_10_01_00;
   logic           evt_ready = 1'b1;

   logic           evt_valid, evt_irq_arm, evt_qinv, evt_dir, evt_bypass, evt_mm;
   logic           evt_enable, evt_error, halt_fetch;
   logic [2:0]     evt_qid;
   logic [IW-1:0]  evt_avail;
   logic [PW-1:0]  evt_port;
   logic [NQ-1:0]  fetch_stop;

   qstat_event_gen u0 (
      .clk(clk), .rst_n(rst_n), .ev_vld(ev_vld), .ev_qid(ev_qid), .ev_inv(ev_inv),
      .ev_pidx_wr(ev_pidx_wr), .ev_pidx(ev_pidx), .ev_arm_wr(ev_arm_wr), .ev_arm(ev_arm),
      .ev_credits(ev_credits), .q_enable(q_enable), .q_error(q_error), .q_dir(q_dir),
      .q_bypass(q_bypass), .q_mm(q_mm), .q_port(q_port), .evt_ready(evt_ready),
      .evt_valid(evt_valid), .evt_qid(evt_qid), .evt_avail(evt_avail),
      .evt_irq_arm(evt_irq_arm), .evt_qinv(evt_qinv), .evt_dir(evt_dir),
      .evt_bypass(evt_bypass), .evt_mm(evt_mm), .evt_enable(evt_enable),
      .evt_error(evt_error), .evt_port(evt_port), .halt_fetch(halt_fetch),
      .fetch_stop(fetch_stop)
   );

   typedef struct {
      int qid; int avail; bit irq; bit inv; int attr; int port;
   } rec_t;

   rec_t          mq[$];
   int            m_last [NQ];
   bit [NQ-1:0]   m_arm, m_stop;
   int            n_chk = 0, n_err = 0;
   bit            done = 0;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // Model of one clock edge, using the inputs currently driven
   task automatic model_edge();
      bit   pop_now;
      rec_t r;
      int   q;
      pop_now = (mq.size() != 0) && evt_ready;
      if (ev_vld) begin
         q = int'(ev_qid);
         r.qid  = q;
         r.attr = {q_dir[q], q_bypass[q], q_mm[q], q_enable[q], q_error[q]};
         r.port = int'(q_port[q*PW +: PW]);
         if (ev_inv) begin
            r.avail = int'(ev_credits); r.irq = 0; r.inv = 1;
            mq.push_back(r);
            m_arm[q] = 0;
            if (q_enable[q]) m_stop[q] = 1;
         end else if (q_enable[q]) begin
            r.inv   = 0;
            r.irq   = ev_arm_wr && ev_arm && !m_arm[q];
            r.avail = ev_pidx_wr ? ((int'(ev_pidx) - m_last[q]) & 16'hFFFF) : 0;
            if (ev_pidx_wr || (ev_arm_wr && ev_arm)) mq.push_back(r);
            if (ev_pidx_wr) m_last[q] = int'(ev_pidx);
            if (ev_arm_wr)  m_arm[q]  = ev_arm;
         end
      end
      for (int i = 0; i < NQ; i++) if (!q_enable[i]) m_stop[i] = 0;
      if (pop_now) void'(mq.pop_front());
   endtask

   task automatic compare();
      bit exp_v;
      exp_v = (mq.size() != 0);
      chk(evt_valid == exp_v, "R9 valid", evt_valid, exp_v);
      if (exp_v && evt_valid) begin
         chk(int'(evt_qid) == mq[0].qid, "R9 order qid", evt_qid, mq[0].qid);
         chk(int'(evt_avail) == mq[0].avail, mq[0].inv ? "R7 credits" : "R2 avail",
             evt_avail, mq[0].avail);
         chk(evt_irq_arm == mq[0].irq, "R3 irq_arm", evt_irq_arm, mq[0].irq);
         chk(evt_qinv == mq[0].inv, "R7 qinv", evt_qinv, mq[0].inv);
         chk(int'({evt_dir, evt_bypass, evt_mm, evt_enable, evt_error}) == mq[0].attr,
             "R8 attrs", {evt_dir, evt_bypass, evt_mm, evt_enable, evt_error}, mq[0].attr);
         chk(int'(evt_port) == mq[0].port, "R8 port", evt_port, mq[0].port);
      end
      chk(halt_fetch == (mq.size() >= 7), "R10 halt", halt_fetch, mq.size() >= 7);
      chk(fetch_stop == m_stop, "R7 fetch_stop", fetch_stop, m_stop);
   endtask

   task automatic tick();
      model_edge();
      @(posedge clk);
      @(negedge clk);
      compare();
   endtask

   task automatic idle_inputs();
      ev_vld = 0; ev_inv = 0; ev_pidx_wr = 0; ev_arm_wr = 0; ev_arm = 0;
   endtask

   task automatic wr(input int q, input bit pw, input int pidx, input bit aw, input bit av);
      ev_vld = 1; ev_qid = 3'(q); ev_inv = 0;
      ev_pidx_wr = pw; ev_pidx = IW'(pidx); ev_arm_wr = aw; ev_arm = av;
      tick();
      idle_inputs();
   endtask

   task automatic inval(input int q, input int cred);
      ev_vld = 1; ev_qid = 3'(q); ev_inv = 1; ev_credits = IW'(cred);
      ev_pidx_wr = 1; ev_pidx = 16'h1234; ev_arm_wr = 1; ev_arm = 1;  // ignored fields
      tick();
      idle_inputs();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog: actual=expired expected=finish");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      int accepted;
      for (int i = 0; i < NQ; i++) m_last[i] = 0;
      m_arm = '0; m_stop = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk(evt_valid == 0, "R1 valid after reset", evt_valid, 0);
      chk(halt_fetch == 0, "R1 halt after reset", halt_fetch, 0);
      chk(fetch_stop == 0, "R1 fetch_stop after reset", fetch_stop, 0);

      // R2 / R11: first index write on queue 0, seen one edge later
      wr(0, 1, 5, 0, 0);
      chk(evt_valid && evt_avail == 5 && !evt_qinv, "R11 R2 first count", evt_avail, 5);
      tick();
      // R2: wraparound 5 -> 3 gives 0xFFFE
      wr(0, 1, 3, 0, 0);
      chk(evt_avail == 16'hFFFE, "R2 wraparound", evt_avail, 16'hFFFE);
      tick();

      // R3: arm set on queue 1 twice
      wr(1, 0, 0, 1, 1);
      chk(evt_valid && evt_irq_arm && evt_avail == 0, "R3 first arm", evt_irq_arm, 1);
      tick();
      wr(1, 0, 0, 1, 1);
      chk(evt_valid && !evt_irq_arm, "R3 repeated arm", evt_irq_arm, 0);
      tick();

      // R4: arm clear gives no record, then re-arm flags again
      wr(1, 0, 0, 1, 0);
      chk(evt_valid == 0, "R4 clear makes no record", evt_valid, 0);
      wr(1, 0, 0, 1, 1);
      chk(evt_irq_arm == 1, "R4 re-arm after clear", evt_irq_arm, 1);
      tick();

      // R5: merged write on queue 2
      wr(2, 1, 40, 1, 1);
      chk(evt_avail == 40 && evt_irq_arm, "R5 merged record", {evt_avail, evt_irq_arm}, {16'd40, 1'b1});
      tick();
      chk(evt_valid == 0, "R5 only one record", evt_valid, 0);

      // R6: queue 3 disabled (bit 3 of q_enable is 0)
      wr(3, 1, 100, 1, 1);
      chk(evt_valid == 0, "R6 disabled ignored", evt_valid, 0);
      q_enable[3] = 1'b1;
      wr(3, 1, 4, 0, 0);
      chk(evt_avail == 4, "R6 index unchanged while disabled", evt_avail, 4);
      tick();

      // R7: invalidation of queue 4 with 9 credits
      inval(4, 9);
      chk(evt_qinv && evt_avail == 9 && !evt_irq_arm, "R7 invalidate record", evt_avail, 9);
      chk(fetch_stop[4] == 1, "R7 stop set", fetch_stop[4], 1);
      q_enable[4] = 1'b0;
      tick();
      chk(fetch_stop[4] == 0, "R7 stop cleared by disable", fetch_stop[4], 1);
      q_enable[4] = 1'b1;
      tick();

      // R9 / R10: hold the output and fill to the halt level
      evt_ready = 1'b0;
      accepted = 0;
      while (!halt_fetch && accepted < 20) begin
         wr(5, 1, 10 * (accepted + 1), 0, 0);
         accepted++;
      end
      chk(accepted == 7, "R10 halt at seven entries", accepted, 7);
      chk(halt_fetch == 1, "R10 halt high", halt_fetch, 1);
      repeat (4) tick();
      evt_ready = 1'b1;
      repeat (9) tick();
      chk(evt_valid == 0, "R9 drained", evt_valid, 0);

      // Mixed traffic
      for (int c = 0; c < 3000; c++) begin
         int k;
         evt_ready = ($urandom_range(0, 3) != 0);
         if ($urandom_range(0, 40) == 0) q_enable[$urandom_range(0, NQ-1)] ^= 1'b1;
         if (!halt_fetch && $urandom_range(0, 2) != 0) begin
            k = $urandom_range(0, 9);
            ev_vld = 1; ev_qid = 3'($urandom_range(0, NQ-1));
            ev_inv = (k == 0);
            ev_credits = IW'($urandom);
            ev_pidx_wr = (k < 6); ev_pidx = IW'($urandom);
            ev_arm_wr = (k >= 4); ev_arm = $urandom_range(0, 1);
         end
         tick();
         idle_inputs();
      end
      evt_ready = 1'b1;
      repeat (12) tick();

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule